// File: doc/BRIEF.md
# Coprocessor Error Interrupt Latch

This block sits on a simple I/O bus and owns a 16-port window set aside for a math coprocessor (by default addresses F0h to FFh). When the coprocessor's error line rises, the block latches two flags: a busy indication and interrupt request 13. Both stay set until software writes to the window. Any byte-sized write anywhere in the window drops the interrupt. Only the two lowest ports of the window also clear the busy flag: the port at offset 0 is the plain clear port, and the port at offset 1 is the reset command port, which also issues a one-cycle reset pulse toward the coprocessor.

The opcode-transfer ports at offsets 8, A and C, and every other offset, decode as ordinary window addresses and do nothing beyond the shared interrupt drop. The block does not service wider writes or any read. Such an access changes no latch state and raises a one-cycle unclaimed-access pulse. A read also sees all ones on the read-data bus in its own cycle. The error input passes through a parameterised synchronizer before edge detection, so the latch sets a fixed number of cycles after the input rises.

Top module: `cop_err_irq`

## Requirements
- R1: An access whose address lies outside the window BASE..BASE+15 changes no output: irq13, busy, cop_rst and unclaimed keep their values, and io_rdata stays zero.
- R2: A rising edge on err_in sets both irq13 and busy on the clock edge SYNC_STAGES+1 cycles after the rising edge of err_in is first sampled. A level held high does not set them again after they are cleared.
- R3: A write with io_size = 0 (byte) to any port in the window leaves irq13 low after the next clock edge.
- R4: A byte write to window offset 0 clears busy on the next clock edge.
- R5: A byte write to window offset 1 clears busy and drives cop_rst high for exactly the following cycle.
- R6: A byte write to any window offset other than 0 or 1, including the opcode ports at offsets 8, A and C, leaves busy unchanged and does not pulse cop_rst.
- R7: A write in the window with io_size other than 0 (1 = 16-bit, 2 = 32-bit) leaves irq13 and busy unchanged and drives unclaimed high for the following cycle.
- R8: A read in the window drives io_rdata to all ones in the same cycle, drives unclaimed high for the following cycle, and leaves irq13 and busy unchanged.
- R9: While rst_n is low, irq13, busy, cop_rst and unclaimed are all low.
- R10: When an error edge and a clearing write fall on the same clock edge, the error wins and irq13 and busy end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| io_addr | input | ADDR_W | I/O port address |
| io_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| err_in | input | 1 | Coprocessor error line, asynchronous |
| io_rdata | output | DATA_W | Read data: all ones during a window read, otherwise zero |
| irq13 | output | 1 | Latched interrupt request 13 |
| busy | output | 1 | Latched busy flag |
| cop_rst | output | 1 | One-cycle coprocessor reset pulse |
| unclaimed | output | 1 | One-cycle pulse for an access the block does not service |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This moves the error-to-latch delay to four edges and tests that the reference model's latency follows the parameter instead of a fixed count. With that depth, the bench can time a clearing write so that it lands exactly on the edge where the detected error takes effect. It keeps the default 16-bit address and F0h base, so it can probe addresses just below the window, just above it, and at an alias that differs only in the high byte.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam int unsigned OFF_CLEAR = 0;
  localparam int unsigned OFF_RESET = 1;
endpackage

// File: rtl/cop_port_decode.sv
module cop_port_decode
  import cop_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h00F0,
  parameter int unsigned WIN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              wr_byte,
  output logic              bad_acc,
  output logic              rd_hit,
  output logic              sel_clear,
  output logic              sel_reset
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:WIN_LOG2];

  logic              in_win;
  logic              is_byte;
  logic [WIN_LOG2-1:0] offset;

  always_comb begin
    in_win    = (io_addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
    offset    = io_addr[WIN_LOG2-1:0];
    is_byte   = (io_size_e'(io_size) == SZ_BYTE);
    wr_byte   = in_win && io_wr && is_byte;
    rd_hit    = in_win && io_rd;
    bad_acc   = rd_hit || (in_win && io_wr && !is_byte);
    sel_clear = in_win && (offset == WIN_LOG2'(OFF_CLEAR));
    sel_reset = in_win && (offset == WIN_LOG2'(OFF_RESET));
  end
endmodule

// File: rtl/cop_err_sync.sv
module cop_err_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_in,
  output logic err_edge
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= err_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign err_edge = chain_q[STAGES-1] && !prev_q;

  // A detected edge lasts one cycle only (R2: level held high does not re-set)
  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_edge |=> !err_edge);
endmodule

// File: rtl/cop_irq_latch.sv
module cop_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_edge,
  input  logic wr_byte,
  input  logic sel_clear,
  input  logic sel_reset,
  input  logic bad_acc,
  output logic irq13,
  output logic busy,
  output logic cop_rst,
  output logic unclaimed
);
  logic irq_q, irq_d;
  logic busy_q, busy_d;
  logic rst_q, rst_d;
  logic unc_q, unc_d;
  logic busy_clr;
  logic irq_en, busy_en;

  always_comb begin
    busy_clr = wr_byte && (sel_clear || sel_reset);
    irq_en   = err_edge || wr_byte;
    busy_en  = err_edge || busy_clr;
    irq_d    = err_edge;
    busy_d   = err_edge;
    rst_d    = wr_byte && sel_reset;
    unc_d    = bad_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
      rst_q  <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      if (irq_en)  irq_q  <= irq_d;
      if (busy_en) busy_q <= busy_d;
      rst_q <= rst_d;
      unc_q <= unc_d;
    end
  end

  assign irq13     = irq_q;
  assign busy      = busy_q;
  assign cop_rst   = rst_q;
  assign unclaimed = unc_q;

  p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_edge |=> (irq13 && busy));
  p_wr_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && !err_edge) |=> !irq13);
  p_clear_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && sel_clear && !err_edge) |=> !busy);
  p_reset_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && sel_reset) |=> cop_rst);
  p_busy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_clear && !sel_reset) |=> busy);
  p_irq_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_byte && !err_edge) |=> $stable(irq13));
  p_unclaimed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> unclaimed);
endmodule

// File: rtl/cop_err_irq.sv
module cop_err_irq #(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'h00F0,
  parameter int unsigned WIN_LOG2    = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              err_in,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq13,
  output logic              busy,
  output logic              cop_rst,
  output logic              unclaimed
);
  logic wr_byte, bad_acc, rd_hit, sel_clear, sel_reset, err_edge;

  cop_port_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .WIN_LOG2(WIN_LOG2)
  ) u_dec (
    .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd),
    .wr_byte(wr_byte), .bad_acc(bad_acc), .rd_hit(rd_hit),
    .sel_clear(sel_clear), .sel_reset(sel_reset)
  );

  cop_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_edge(err_edge)
  );

  cop_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .err_edge(err_edge), .wr_byte(wr_byte),
    .sel_clear(sel_clear), .sel_reset(sel_reset), .bad_acc(bad_acc),
    .irq13(irq13), .busy(busy), .cop_rst(cop_rst), .unclaimed(unclaimed)
  );

  assign io_rdata = rd_hit ? '1 : '0;

  // R1: no access outside the window may report as unclaimed
  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[ADDR_W-1:WIN_LOG2] != BASE[ADDR_W-1:WIN_LOG2]) |=> !unclaimed && !cop_rst);
endmodule

// File: tb/sim_cop_err_irq.sv
module sim_cop_err_irq;
  localparam int unsigned SYNC = 3;
  localparam int unsigned AW   = 16;
  localparam int unsigned DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] io_addr = '0;
  logic [1:0]    io_size = 2'd0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic          err_in = 1'b0;
  logic [DW-1:0] io_rdata;
  logic          irq13, busy, cop_rst, unclaimed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  cop_err_irq #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
    .io_wr(io_wr), .io_rd(io_rd), .err_in(err_in), .io_rdata(io_rdata),
    .irq13(irq13), .busy(busy), .cop_rst(cop_rst), .unclaimed(unclaimed)
  );

  // Behavioural reference model
  bit hist[$];
  bit m_irq, m_busy, m_rst, m_unc;

  function automatic bit in_window(logic [AW-1:0] a);
    return (a >= 16'h00F0) && (a <= 16'h00FF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      m_irq = 0; m_busy = 0; m_rst = 0; m_unc = 0;
    end else begin
      bit edge_seen, wb;
      edge_seen = hist[SYNC-1] && !hist[SYNC];
      wb = io_wr && io_size == 2'd0 && in_window(io_addr);
      if (edge_seen) begin m_irq = 1; m_busy = 1; end
      else begin
        if (wb) m_irq = 0;
        if (wb && (io_addr == 16'h00F0 || io_addr == 16'h00F1)) m_busy = 0;
      end
      m_rst = wb && io_addr == 16'h00F1;
      m_unc = in_window(io_addr) && (io_rd || (io_wr && io_size != 2'd0));
      hist.push_front(err_in);
      void'(hist.pop_back());
    end
  end

  task automatic cmp(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("irq13", DW'(irq13), DW'(m_irq));
    cmp("busy", DW'(busy), DW'(m_busy));
    cmp("cop_rst", DW'(cop_rst), DW'(m_rst));
    cmp("unclaimed", DW'(unclaimed), DW'(m_unc));
    cmp("io_rdata", io_rdata, (io_rd && in_window(io_addr)) ? '1 : '0);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      io_wr = 0; io_rd = 0;
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [1:0] sz);
    @(negedge clk); #1;
    io_addr = a; io_size = sz; io_wr = 1; io_rd = 0;
    idle(1);
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk); #1;
    io_addr = a; io_size = 2'd0; io_rd = 1; io_wr = 0;
    idle(1);
  endtask

  task automatic err_pulse();
    @(negedge clk); #1; err_in = 1;
    idle(SYNC + 2);
    @(negedge clk); #1; err_in = 0;
    idle(2);
  endtask

  initial begin
    cur_req = "R9"; idle(3);
    @(negedge clk); #1; rst_n = 1;
    idle(2);
    cur_req = "R2"; @(negedge clk); #1; err_in = 1; idle(SYNC + 3);
    cur_req = "R3"; wr(16'h00F5, 2'd0); idle(2);
    cur_req = "R2"; idle(SYNC + 2);
    @(negedge clk); #1; err_in = 0; idle(2);
    cur_req = "R6"; err_pulse();
    wr(16'h00F8, 2'd0); wr(16'h00FA, 2'd0); wr(16'h00FC, 2'd0); wr(16'h00FF, 2'd0);
    cur_req = "R4"; wr(16'h00F0, 2'd0); idle(2);
    cur_req = "R5"; err_pulse(); wr(16'h00F1, 2'd0); idle(2);
    cur_req = "R7"; err_pulse(); wr(16'h00F0, 2'd1); wr(16'h00F3, 2'd2); idle(2);
    cur_req = "R8"; rd(16'h00F0); rd(16'h00FF); idle(2);
    cur_req = "R1"; wr(16'h00EF, 2'd0); wr(16'h0100, 2'd0); wr(16'h01F0, 2'd0);
    rd(16'h00EF); rd(16'h0100); idle(2);
    cur_req = "R3"; wr(16'h00F0, 2'd0); idle(2);
    cur_req = "R10";
    @(negedge clk); #1; err_in = 1;
    repeat (SYNC) @(negedge clk);
    #1; io_addr = 16'h00F0; io_size = 2'd0; io_wr = 1;
    idle(3);
    @(negedge clk); #1; err_in = 0; idle(2);
    cur_req = "R9";
    @(negedge clk); #1; rst_n = 0; idle(2);
    @(negedge clk); #1; rst_n = 1; idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog %s actual=running expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule